// File: doc/BRIEF.md
# Switched-Capacitor Column Output-Drive Controller

This block decides, cycle by cycle, when each of four switched-capacitor analog columns may connect its amplifier to its output bus. Each column runs a two-phase, non-overlapping clock with phases A and B. The block builds that clock from one of eight digital source pulses, sampled on a single system clock. By default a column drives its bus only in the later half of phase B. For the rest of the time the bus floats and keeps its last driven level, so the bus and its capacitance act as a sample-and-hold. A per-column full-phase input and a global hold-bypass bit in the control register each widen the drive window to the whole of phase B.

Software sets the block up through one 8-bit control register at a single address. The register holds two 3-bit source-select fields and the hold-bypass bit. Columns 0 and 1 share the lower select field, and columns 2 and 3 share the upper one. A column picks up a new select value only at a phase boundary, so a phase is never cut short by a change of source.

Top module: `sc_bus_drive_ctl`

## Requirements
- R1: During and right after reset, `cfg_rdata` reads 0 and all `phi1`, `phi2` and `drive_en` bits are 0. Every column begins in the gap that comes before phase A, and every column has source 0 selected.
- R2: A write with `cfg_wr`=1 and `cfg_addr` equal to the configured address stores `cfg_wdata[6:0]` in the register. `cfg_rdata` shows the new value in the next cycle. Bit 7 always reads 0, and a write to any other address leaves the register unchanged.
- R3: Each column steps through a six-tick cycle on pulses of its selected source: phase A (`phi1`) for 2 ticks, a gap for 1 tick, phase B (`phi2`) for 2 ticks, and a gap for 1 tick. The first tick after reset enters phase A. The outputs change in the cycle after the clock edge that samples the tick.
- R4: A select code s (0 to 7) makes `src_tick[s]` the column's source. Columns 0 and 1 read the code from register bits 2:0, and columns 2 and 3 read it from bits 5:3. Pulses on sources that are not selected leave the column's outputs unchanged.
- R5: With the hold-bypass bit, register bit 6, at 0 and the column's `col_full_phase` at 0, `drive_en` is 1 only in the second tick of phase B for a column whose `col_en` is 1.
- R6: With `col_full_phase[c]`=1, column c asserts `drive_en` for the whole of phase B.
- R7: With register bit 6 at 1, every enabled column asserts `drive_en` for the whole of its phase B.
- R8: A column with `col_en`=0 never asserts `drive_en`, whatever the values of bit 6 and `col_full_phase`.
- R9: A column loads a new select code only on the tick of its current source that moves it out of a gap. Before that tick, pulses of the newly coded source have no effect on the column.
- R10: `phi1` and `phi2` of a column are never 1 at the same time, and a gap always separates them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register contents (bit 7 always 0) |
| src_tick | input | 8 | One-cycle pulses from the eight digital clock sources |
| col_en | input | 4 | Per-column output enable |
| col_full_phase | input | 4 | Per-column request to drive for all of phase B |
| phi1 | output | 4 | Per-column phase A |
| phi2 | output | 4 | Per-column phase B |
| drive_en | output | 4 | Per-column output-bus drive enable |

## Verification
The assertions take `src_tick` to be single-cycle pulses. They also take `col_en`, `col_full_phase` and the register as stable whenever they are used to judge `drive_en` over the cycles around a tick. The bench changes all of these inputs only on falling edges and between tick pulses. Each pulse lasts exactly one system-clock cycle and is followed by at least one idle cycle. The bench drives each column's six-tick cycle against every source code and every combination of full-phase, hold-bypass and enable bits, including pulses on sources that are not selected and select changes in the middle of a phase.

// File: rtl/sc_drv_pkg.sv
package sc_drv_pkg;
  localparam int CFG_W    = 8;
  localparam int SEL_W    = 3;
  localparam int BYP_BIT  = 6;

  // stored register image (bit 7 is not stored)
  typedef struct packed {
    logic             hold_bypass;
    logic [SEL_W-1:0] sel_hi;
    logic [SEL_W-1:0] sel_lo;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_PHA  = 2'd0,
    ST_GAPA = 2'd1,
    ST_PHB  = 2'd2,
    ST_GAPB = 2'd3
  } phase_t;

  function automatic phase_t next_phase(input phase_t s);
    case (s)
      ST_PHA:  return ST_GAPA;
      ST_GAPA: return ST_PHB;
      ST_PHB:  return ST_GAPB;
      default: return ST_PHA;
    endcase
  endfunction
endpackage

// File: rtl/sc_drv_cfg.sv
module sc_drv_cfg
  import sc_drv_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output cfg_t              cfg,
  output logic [CFG_W-1:0]  rdata
);
  localparam int STORE_W = $bits(cfg_t);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_ADDR);

  cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr && (addr == MY_ADDR)) begin
      cfg_q <= cfg_t'(wdata[STORE_W-1:0]);
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {{(CFG_W-STORE_W){1'b0}}, cfg_q};
endmodule

// File: rtl/sc_drv_phase.sv
module sc_drv_phase
  import sc_drv_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PHASE_LEN = 2,
  parameter int GAP_LEN   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel_field,
  output logic               pha_nx,
  output logic               phb_nx,
  output logic               late_nx
);
  localparam int MAXLEN = (PHASE_LEN > GAP_LEN) ? PHASE_LEN : GAP_LEN;
  localparam int CNT_W  = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
  localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PHASE_LEN - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_LEN - 1);
  localparam logic [CNT_W-1:0] LATE_AT  = CNT_W'(PHASE_LEN / 2);

  phase_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             tick;
  logic             at_end;
  logic             in_gap;

  assign tick   = src_tick[sel_q];
  assign in_gap = (st_q == ST_GAPA) || (st_q == ST_GAPB);
  assign at_end = in_gap ? (cnt_q == GAP_LAST) : (cnt_q == PH_LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sel_d = sel_q;
    if (tick) begin
      if (at_end) begin
        st_d  = next_phase(st_q);
        cnt_d = '0;
        if (in_gap) sel_d = sel_field;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_GAPB;
      cnt_q <= GAP_LAST;
      sel_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign pha_nx  = (st_d == ST_PHA);
  assign phb_nx  = (st_d == ST_PHB);
  assign late_nx = phb_nx && (cnt_d >= LATE_AT);
endmodule

// File: rtl/sc_drv_gate.sv
module sc_drv_gate (
  input  logic clk,
  input  logic rst,
  input  logic col_en,
  input  logic widen,
  input  logic pha_nx,
  input  logic phb_nx,
  input  logic late_nx,
  output logic phi1,
  output logic phi2,
  output logic drive_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phi1     <= 1'b0;
      phi2     <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      phi1     <= pha_nx;
      phi2     <= phb_nx;
      drive_en <= col_en && phb_nx && (late_nx || widen);
    end
  end
endmodule

// File: rtl/sc_bus_drive_ctl.sv
module sc_bus_drive_ctl
  import sc_drv_pkg::*;
#(
  parameter int NUM_COLS  = 4,
  parameter int NUM_SRC   = 8,
  parameter int ADDR_W    = 4,
  parameter int CFG_ADDR  = 0,
  parameter int PHASE_LEN = 2,
  parameter int GAP_LEN   = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic [NUM_SRC-1:0]  src_tick,
  input  logic [NUM_COLS-1:0] col_en,
  input  logic [NUM_COLS-1:0] col_full_phase,
  output logic [NUM_COLS-1:0] phi1,
  output logic [NUM_COLS-1:0] phi2,
  output logic [NUM_COLS-1:0] drive_en
);
  localparam int LO_COLS = NUM_COLS / 2;

  cfg_t cfg;

  sc_drv_cfg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [SEL_W-1:0] sel_field;
    logic             pha_nx, phb_nx, late_nx;

    if (c < LO_COLS) begin : g_lo
      assign sel_field = cfg.sel_lo;
    end else begin : g_hi
      assign sel_field = cfg.sel_hi;
    end

    sc_drv_phase #(
      .NUM_SRC(NUM_SRC), .PHASE_LEN(PHASE_LEN), .GAP_LEN(GAP_LEN)
    ) u_phase (
      .clk       (clk),
      .rst       (rst),
      .src_tick  (src_tick),
      .sel_field (sel_field),
      .pha_nx    (pha_nx),
      .phb_nx    (phb_nx),
      .late_nx   (late_nx)
    );

    sc_drv_gate u_gate (
      .clk      (clk),
      .rst      (rst),
      .col_en   (col_en[c]),
      .widen    (cfg.hold_bypass || col_full_phase[c]),
      .pha_nx   (pha_nx),
      .phb_nx   (phb_nx),
      .late_nx  (late_nx),
      .phi1     (phi1[c]),
      .phi2     (phi2[c]),
      .drive_en (drive_en[c])
    );
  end
endmodule

// File: rtl/sc_drv_chk.sv
module sc_drv_chk #(
  parameter int NUM_COLS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [7:0]          cfg_rdata,
  input logic [NUM_COLS-1:0] col_en,
  input logic [NUM_COLS-1:0] col_full_phase,
  input logic [NUM_COLS-1:0] phi1,
  input logic [NUM_COLS-1:0] phi2,
  input logic [NUM_COLS-1:0] drive_en
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[7] == 1'b0);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_c
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
      !(phi1[c] && phi2[c]));
    assert_gap_before_b_R10: assert property (@(posedge clk) disable iff (rst)
      $rose(phi2[c]) |-> !$past(phi1[c]));
    assert_drive_in_b_R5: assert property (@(posedge clk) disable iff (rst)
      drive_en[c] |-> phi2[c]);
    assert_early_b_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      ($rose(phi2[c]) && !$past(cfg_rdata[6]) && !$past(col_full_phase[c]))
        |-> !drive_en[c]);
    assert_full_phase_R6: assert property (@(posedge clk) disable iff (rst)
      (phi2[c] && $past(col_full_phase[c]) && $past(col_en[c])) |-> drive_en[c]);
    assert_bypass_R7: assert property (@(posedge clk) disable iff (rst)
      (phi2[c] && $past(cfg_rdata[6]) && $past(col_en[c])) |-> drive_en[c]);
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      drive_en[c] |-> $past(col_en[c]));
  end
endmodule

bind sc_bus_drive_ctl sc_drv_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_rdata      (cfg_rdata),
  .col_en         (col_en),
  .col_full_phase (col_full_phase),
  .phi1           (phi1),
  .phi2           (phi2),
  .drive_en       (drive_en)
);

// File: tb/sim_sc_bus_drive_ctl.sv
module sim_sc_bus_drive_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [7:0] src_tick = '0;
  logic [3:0] col_en = '0;
  logic [3:0] col_full_phase = '0;
  logic [3:0] phi1, phi2, drive_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model
  logic [7:0] reg_m = '0;
  int pos_m [4];
  int esel  [4];

  always #5 clk = ~clk;

  sc_bus_drive_ctl u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_tick(src_tick),
    .col_en(col_en), .col_full_phase(col_full_phase),
    .phi1(phi1), .phi2(phi2), .drive_en(drive_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a == 4'd0) reg_m = d & 8'h7F;
  endtask

  function automatic int field_of(input int c);
    return (c < 2) ? int'(reg_m[2:0]) : int'(reg_m[5:3]);
  endfunction

  task automatic tick(input logic [7:0] mask, input string ptag, input string dtag);
    logic [3:0] e1, e2, ed;
    @(negedge clk);
    src_tick = mask;
    @(negedge clk);
    src_tick = '0;
    for (int c = 0; c < 4; c++) begin
      if (mask[esel[c]]) begin
        if (pos_m[c] == 2 || pos_m[c] == 5) esel[c] = field_of(c);
        pos_m[c] = (pos_m[c] + 1) % 6;
      end
      e1[c] = (pos_m[c] < 2);
      e2[c] = (pos_m[c] == 3 || pos_m[c] == 4);
      ed[c] = col_en[c] && e2[c] &&
              (pos_m[c] == 4 || reg_m[6] || col_full_phase[c]);
    end
    chk(ptag, {4'h0, phi1}, {4'h0, e1});
    chk(ptag, {4'h0, phi2}, {4'h0, e2});
    chk(dtag, {4'h0, drive_en}, {4'h0, ed});
    chk("R10 overlap", {4'h0, phi1 & phi2}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string dt;
    for (int c = 0; c < 4; c++) begin pos_m[c] = 5; esel[c] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", cfg_rdata, 8'h00);
    chk("R1 phases", {phi1, phi2}, 8'h00);
    chk("R1 drive", {4'h0, drive_en}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {phi1, phi2}, 8'h00);

    // R2: register access
    wr(4'd0, 8'hFF);
    chk("R2 write reads back, bit7 zero", cfg_rdata, 8'h7F);
    wr(4'd5, 8'h00);
    chk("R2 other address ignored", cfg_rdata, 8'h7F);
    wr(4'd0, 8'h2C);
    chk("R2 write pattern", cfg_rdata, 8'h2C);
    wr(4'd0, 8'h00);
    chk("R2 clear", cfg_rdata, 8'h00);

    // R3/R4: every source code on both fields, pulses on all sources
    col_en = 4'hF; col_full_phase = 4'h0;
    for (int s = 0; s < 8; s++) begin
      wr(4'd0, {2'b00, 3'(7 - s), 3'(s)});
      for (int k = 0; k < 30; k++)
        tick(8'(1 << ((k * 3 + s) % 8)), "R4 select/R3 sequence", "R5 default drive");
    end

    // R5..R8: widening and enable sweep
    wr(4'd0, 8'h00);
    for (int k = 0; k < 12; k++) tick(8'hFF, "R3 settle", "R5 settle");
    for (int sh = 0; sh < 2; sh++) begin
      wr(4'd0, sh ? 8'h40 : 8'h00);
      for (int m = 0; m < 16; m++) begin
        for (int e = 0; e < 4; e++) begin
          col_full_phase = 4'(m);
          col_en = (e == 0) ? 4'hF : (e == 1) ? 4'h5 : (e == 2) ? 4'hA : 4'h0;
          if (col_en != 4'hF) dt = "R8 disabled column";
          else if (sh != 0)   dt = "R7 hold bypass";
          else if (m != 0)    dt = "R6 full phase";
          else                dt = "R5 late half only";
          for (int k = 0; k < 6; k++) tick(8'h01, "R3 sequence", dt);
        end
      end
    end

    // R9: select change waits for a phase boundary
    col_en = 4'hF; col_full_phase = 4'h0;
    wr(4'd0, 8'h00);
    for (int k = 0; k < 7; k++) tick(8'h01, "R9 prep", "R9 prep");
    wr(4'd0, 8'h1B);   // lo field 3, hi field 3
    for (int k = 0; k < 3; k++) tick(8'h08, "R9 new source ignored", "R9 drive");
    for (int k = 0; k < 3; k++) tick(8'h01, "R9 old source until boundary", "R9 drive");
    for (int k = 0; k < 8; k++) tick(8'h08, "R9 new source active", "R9 drive");
    for (int k = 0; k < 4; k++) tick(8'h01, "R9 old source ignored", "R9 drive");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule